// File: doc/BRIEF.md
# Cooperative Context Swap Unit

This block gives a simple, non-pipelined processor core two cooperating threads of execution without any scheduler hardware. It holds the core's live context (a program counter plus zero and carry flags) and one spare saved context. A thread gives up the core by issuing a swap. The swap parks the address of the instruction after the swap, together with the current flags, in the spare slot. In the same step the core resumes from whatever context the spare slot held before.

Two further operations let software inspect or seed the spare slot. A read returns it packed into a 32-bit word, and a write loads it from such a word. Outside these operations the live context follows the core's ordinary control: it steps to the next instruction, takes a jump, or updates its flags from the execution result. The decoder raises one strobe for each of the three operations, and every operation completes in a single clock cycle.

Top module: `ctx_swap_unit`

## Requirements
- R1: A synchronous active-high reset clears the live PC, the live Z and C flags, and the saved context to zero. After reset a read returns 0.
- R2: While `op_get` is high, `rd_data` shows the saved context in the same cycle. C is in bit 10, Z in bit 9, the PC in bits 8:0, and bits 31:11 are zero. While `op_get` is low, `rd_data` is 0.
- R3: With `op_set` high and `op_swap` low, the saved context takes C from `wr_data[10]`, Z from `wr_data[9]` and the PC from `wr_data[8:0]` at the clock edge. Bits 31:11 of `wr_data` are ignored.
- R4: With `op_swap` high, at the clock edge the saved context becomes (live PC + 1, live Z, live C). In the same edge the live PC, Z and C take the previous saved values, so the next fetch address is the restored PC.
- R5: When `op_set` and `op_swap` are high in the same cycle, the swap is performed and the write data is discarded.
- R6: During a swap, `jump_en`, `step_en` and `flag_we` have no effect on the live context.
- R7: Outside a swap, `jump_en` loads `jump_pc` and takes priority over `step_en`. `step_en` adds 1 to the PC modulo 512, and `flag_we` loads `z_in`/`c_in`. Otherwise the PC and flags hold.
- R8: The PC + 1 stored by a swap wraps from 511 to 0.
- R9: Two swaps in consecutive cycles return the live context to the one that was running before the first swap, with its PC advanced by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_get | input | 1 | Decode strobe: read the saved context |
| op_set | input | 1 | Decode strobe: write the saved context |
| op_swap | input | 1 | Decode strobe: exchange live and saved contexts |
| wr_data | input | 32 | Packed context for a write |
| rd_data | output | 32 | Packed saved context during a read, else 0 |
| jump_en | input | 1 | Load `jump_pc` into the live PC |
| jump_pc | input | 9 | Jump target |
| step_en | input | 1 | Advance the live PC by one |
| flag_we | input | 1 | Load the live flags from `z_in`/`c_in` |
| z_in | input | 1 | New zero flag |
| c_in | input | 1 | New carry flag |
| pc_q | output | 9 | Live program counter (fetch address) |
| z_q | output | 1 | Live zero flag |
| c_q | output | 1 | Live carry flag |

## Verification
A read is combinational, so `rd_data` is due in the same cycle as `op_get`. The bench captures it after the inputs settle and before the next rising edge. Writes, swaps, jumps, steps and flag loads each pass through one register, so their effect on `pc_q`, `z_q`, `c_q` and on a later read is due just after the next rising edge. The driver records the expected values for that edge in a queue, and the monitor compares them 2 ns after the edge. The monitor pops exactly one entry per edge, so every result is checked in the cycle it becomes due.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
    localparam int PC_W   = 9;
    localparam int WORD_W = 32;
    localparam int Z_POS  = PC_W;
    localparam int C_POS  = PC_W + 1;

    typedef struct packed {
        logic            c;
        logic            z;
        logic [PC_W-1:0] pc;
    } ctx_t;

    localparam int CTX_W = $bits(ctx_t);

    typedef enum logic [1:0] {
        SAVE_HOLD  = 2'd0,
        SAVE_LOAD  = 2'd1,
        SAVE_STORE = 2'd2
    } save_act_e;

    typedef enum logic [1:0] {
        LIVE_HOLD    = 2'd0,
        LIVE_STEP    = 2'd1,
        LIVE_JUMP    = 2'd2,
        LIVE_RESTORE = 2'd3
    } live_act_e;

    function automatic logic [WORD_W-1:0] pack_ctx(input ctx_t x);
        logic [WORD_W-1:0] w;
        w             = '0;
        w[PC_W-1:0]   = x.pc;
        w[Z_POS]      = x.z;
        w[C_POS]      = x.c;
        return w;
    endfunction

    function automatic ctx_t unpack_ctx(input logic [WORD_W-1:0] w);
        ctx_t x;
        x.pc = w[PC_W-1:0];
        x.z  = w[Z_POS];
        x.c  = w[C_POS];
        return x;
    endfunction

    function automatic ctx_t next_instr(input ctx_t x);
        ctx_t y;
        y    = x;
        y.pc = x.pc + PC_W'(1);
        return y;
    endfunction
endpackage

// File: rtl/ctx_swap_ctrl.sv
module ctx_swap_ctrl
    import ctx_pkg::*;
(
    input  logic      op_set,
    input  logic      op_swap,
    input  logic      jump_en,
    input  logic      step_en,
    output save_act_e save_act,
    output live_act_e live_act
);
    always_comb begin
        if (op_swap)      save_act = SAVE_STORE;
        else if (op_set)  save_act = SAVE_LOAD;
        else              save_act = SAVE_HOLD;
    end

    always_comb begin
        if (op_swap)      live_act = LIVE_RESTORE;
        else if (jump_en) live_act = LIVE_JUMP;
        else if (step_en) live_act = LIVE_STEP;
        else              live_act = LIVE_HOLD;
    end
endmodule

// File: rtl/ctx_save_reg.sv
module ctx_save_reg
    import ctx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  save_act_e act,
    input  ctx_t      live,
    input  ctx_t      wr_ctx,
    output ctx_t      saved
);
    always_ff @(posedge clk) begin
        if (rst) begin
            saved <= '0;
        end else begin
            case (act)
                SAVE_STORE: saved <= next_instr(live);
                SAVE_LOAD:  saved <= wr_ctx;
                default:    saved <= saved;
            endcase
        end
    end

    // R4 and R8: the stored PC is the live PC plus one, wrapping modulo 2^PC_W
    a_r4_store_next_pc: assert property (@(posedge clk) disable iff (rst)
        (act == SAVE_STORE) |=> (saved.pc == PC_W'($past(live.pc) + 1'b1)));

    a_r4_store_flags: assert property (@(posedge clk) disable iff (rst)
        (act == SAVE_STORE) |=> (saved.z == $past(live.z) && saved.c == $past(live.c)));

    a_r3_write_loads: assert property (@(posedge clk) disable iff (rst)
        (act == SAVE_LOAD) |=> (saved == $past(wr_ctx)));

    a_r5_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (act == SAVE_HOLD) |=> $stable(saved));
endmodule

// File: rtl/ctx_live_reg.sv
module ctx_live_reg
    import ctx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  live_act_e       act,
    input  ctx_t            saved,
    input  logic [PC_W-1:0] jump_pc,
    input  logic            flag_we,
    input  logic            z_in,
    input  logic            c_in,
    output ctx_t            live
);
    ctx_t nxt;

    always_comb begin
        nxt = live;
        case (act)
            LIVE_RESTORE: nxt = saved;
            LIVE_JUMP:    nxt.pc = jump_pc;
            LIVE_STEP:    nxt.pc = live.pc + PC_W'(1);
            default:      nxt.pc = live.pc;
        endcase
        if (act != LIVE_RESTORE && flag_we) begin
            nxt.z = z_in;
            nxt.c = c_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) live <= '0;
        else     live <= nxt;
    end

    // R4 and R6: a swap restores the whole context from the saved slot
    a_r4_restore: assert property (@(posedge clk) disable iff (rst)
        (act == LIVE_RESTORE) |=> (live == $past(saved)));

    a_r7_step_inc: assert property (@(posedge clk) disable iff (rst)
        (act == LIVE_STEP) |=> (live.pc == PC_W'($past(live.pc) + 1'b1)));

    a_r7_pc_hold: assert property (@(posedge clk) disable iff (rst)
        (act == LIVE_HOLD) |=> $stable(live.pc));

    a_r7_flag_hold: assert property (@(posedge clk) disable iff (rst)
        (act != LIVE_RESTORE && !flag_we) |=> ($stable(live.z) && $stable(live.c)));
endmodule

// File: rtl/ctx_swap_unit.sv
module ctx_swap_unit
    import ctx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_get,
    input  logic              op_set,
    input  logic              op_swap,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic              jump_en,
    input  logic [PC_W-1:0]   jump_pc,
    input  logic              step_en,
    input  logic              flag_we,
    input  logic              z_in,
    input  logic              c_in,
    output logic [PC_W-1:0]   pc_q,
    output logic              z_q,
    output logic              c_q
);
    save_act_e save_act;
    live_act_e live_act;
    ctx_t      saved;
    ctx_t      live;
    ctx_t      wr_ctx;

    assign wr_ctx = unpack_ctx(wr_data);

    ctx_swap_ctrl u_ctrl (
        .op_set   (op_set),
        .op_swap  (op_swap),
        .jump_en  (jump_en),
        .step_en  (step_en),
        .save_act (save_act),
        .live_act (live_act)
    );

    ctx_save_reg u_save (
        .clk    (clk),
        .rst    (rst),
        .act    (save_act),
        .live   (live),
        .wr_ctx (wr_ctx),
        .saved  (saved)
    );

    ctx_live_reg u_live (
        .clk     (clk),
        .rst     (rst),
        .act     (live_act),
        .saved   (saved),
        .jump_pc (jump_pc),
        .flag_we (flag_we),
        .z_in    (z_in),
        .c_in    (c_in),
        .live    (live)
    );

    assign rd_data = op_get ? pack_ctx(saved) : '0;
    assign pc_q    = live.pc;
    assign z_q     = live.z;
    assign c_q     = live.c;

    // R2: upper read bits are always zero
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
        rd_data[WORD_W-1:C_POS+1] == '0);

    // R9: back-to-back swaps bring back the earlier context, PC advanced by one
    a_r9_double_swap: assert property (@(posedge clk) disable iff (rst)
        (op_swap && $past(op_swap) && !$past(rst)) |=>
            (pc_q == PC_W'($past(pc_q, 2) + 1'b1)));
endmodule

// File: tb/ctx_swap_unit_test.sv
module ctx_swap_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_get, op_set, op_swap;
    logic [31:0] wr_data, rd_data;
    logic        jump_en, step_en, flag_we, z_in, c_in;
    logic [8:0]  jump_pc, pc_q;
    logic        z_q, c_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        logic [8:0]  pc;
        logic        z;
        logic        c;
        logic [31:0] rd_obs;
        logic [31:0] rd_exp;
        string       tag;
    } item_t;

    item_t q[$];

    // bench model
    logic [8:0] m_pc, t_pc;
    logic       m_z, m_c, t_z, t_c;

    always #5 clk = ~clk;

    ctx_swap_unit uut (
        .clk(clk), .rst(rst), .op_get(op_get), .op_set(op_set), .op_swap(op_swap),
        .wr_data(wr_data), .rd_data(rd_data), .jump_en(jump_en), .jump_pc(jump_pc),
        .step_en(step_en), .flag_we(flag_we), .z_in(z_in), .c_in(c_in),
        .pc_q(pc_q), .z_q(z_q), .c_q(c_q)
    );

    task automatic step(input logic g, input logic s, input logic w, input logic [31:0] wd,
                        input logic j, input logic [8:0] jp, input logic a,
                        input logic fw, input logic fz, input logic fc, input string tag);
        item_t it;
        logic [8:0] npc, ntpc;
        logic nz, nc, ntz, ntc;
        @(negedge clk);
        op_get = g; op_set = s; op_swap = w; wr_data = wd;
        jump_en = j; jump_pc = jp; step_en = a; flag_we = fw; z_in = fz; c_in = fc;
        #1;
        it.rd_obs = rd_data;
        it.rd_exp = g ? {21'd0, t_c, t_z, t_pc} : 32'd0;
        npc = m_pc; nz = m_z; nc = m_c; ntpc = t_pc; ntz = t_z; ntc = t_c;
        if (w) begin
            ntpc = m_pc + 9'd1; ntz = m_z; ntc = m_c;
            npc = t_pc; nz = t_z; nc = t_c;
        end else begin
            if (s) begin ntpc = wd[8:0]; ntz = wd[9]; ntc = wd[10]; end
            if (j) npc = jp;
            else if (a) npc = m_pc + 9'd1;
            if (fw) begin nz = fz; nc = fc; end
        end
        m_pc = npc; m_z = nz; m_c = nc; t_pc = ntpc; t_z = ntz; t_c = ntc;
        it.pc = npc; it.z = nz; it.c = nc; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic idle(input string tag);
        step(0, 0, 0, 32'd0, 0, 9'd0, 0, 0, 0, 0, tag);
    endtask

    task automatic get(input string tag);
        step(1, 0, 0, 32'd0, 0, 9'd0, 0, 0, 0, 0, tag);
    endtask

    // monitor: compares each queued item 2 ns after the edge it is due at
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (it.rd_obs !== it.rd_exp) begin
                    fails++;
                    $display("FAIL %s rd_data: actual %h expected %h", it.tag, it.rd_obs, it.rd_exp);
                end
                checks++;
                if (pc_q !== it.pc || z_q !== it.z || c_q !== it.c) begin
                    fails++;
                    $display("FAIL %s live ctx: actual pc=%0d z=%0b c=%0b expected pc=%0d z=%0b c=%0b",
                             it.tag, pc_q, z_q, c_q, it.pc, it.z, it.c);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        op_get = 0; op_set = 0; op_swap = 0; wr_data = 0; jump_en = 0; jump_pc = 0;
        step_en = 0; flag_we = 0; z_in = 0; c_in = 0;
        m_pc = 0; m_z = 0; m_c = 0; t_pc = 0; t_z = 0; t_c = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset values
        checks++;
        if (pc_q !== 9'd0 || z_q !== 1'b0 || c_q !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: actual pc=%0d z=%0b c=%0b expected 0 0 0", pc_q, z_q, c_q);
        end
        get("R1");
        // R7: stepping, jumping, flag loads, holding
        step(0, 0, 0, 0, 0, 9'd0, 1, 0, 0, 0, "R7");
        step(0, 0, 0, 0, 0, 9'd0, 1, 0, 0, 0, "R7");
        step(0, 0, 0, 0, 1, 9'd100, 1, 0, 0, 0, "R7");
        step(0, 0, 0, 0, 0, 9'd0, 0, 1, 1, 0, "R7");
        idle("R7");
        // R3: write with upper bits set, then read back (R2)
        step(0, 1, 0, 32'hFFFF_F800 | 32'h5A5, 0, 9'd0, 0, 0, 0, 0, "R3");
        get("R2");
        idle("R2");
        // R4 and R6: swap while jump, step and flag write are asserted
        step(0, 0, 1, 0, 1, 9'd7, 1, 1, 0, 1, "R6");
        get("R4");
        // R9: two swaps back to back
        step(0, 0, 1, 0, 0, 9'd0, 0, 0, 0, 0, "R9");
        step(0, 0, 1, 0, 0, 9'd0, 0, 0, 0, 0, "R9");
        get("R9");
        // R5: write and swap together
        step(0, 1, 1, 32'h0000_0333, 0, 9'd0, 0, 0, 0, 0, "R5");
        get("R5");
        // R8: wrap of the stored PC
        step(0, 0, 0, 0, 1, 9'd511, 0, 1, 1, 1, "R8");
        step(0, 0, 1, 0, 0, 9'd0, 0, 0, 0, 0, "R8");
        get("R8");
        step(0, 0, 0, 0, 0, 9'd0, 1, 0, 0, 0, "R7");
        step(0, 0, 0, 0, 0, 9'd0, 1, 0, 0, 0, "R7");
        idle("R2");
        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule